// File: doc/BRIEF.md
# Boundary-Scan Test Port

This block is the serial test port of a memory device. A 16-state controller, clocked by the test clock and steered by the mode-select input, moves data between the serial input and the serial output through one of four shift paths:

- a 3-bit instruction register;
- a 32-bit identification register;
- a 1-bit bypass cell;
- a boundary register whose cells mirror the device's input pins, output data pins and a shared output-enable.

The active instruction chooses which data path sits between the serial pins. It also decides who controls the output pads: the functional core, the boundary register's hold latch, or nobody (high impedance).

The functional input path is never gated. Pin values always reach the core unchanged, whatever the instruction. Serial output data is launched on the falling test-clock edge and is enabled only while a shift state is active.

Top module: `scan_port`

## Requirements
- R1: Asserting `rst_ni` low asynchronously puts the controller in Test-Logic-Reset, loads the IDCODE instruction (001), clears the output hold latch and disables the serial output.
- R2: Five consecutive rising test-clock edges with `tms_i` high reach Test-Logic-Reset from any state. While in that state the instruction becomes IDCODE on the next falling edge.
- R3: The controller follows the standard 16-state test-port state graph, including the pause and exit-2 loops, without disturbing the data register being shifted.
- R4: `tdo_oe_o` is high only while the controller is in Shift-IR or Shift-DR. `tdo_o` changes on the falling edge and presents the least-significant bit of the selected register first.
- R5: Instruction codes are 000 EXTEST, 001 IDCODE, 010 SAMPLE-Z, 100 SAMPLE/PRELOAD and 111 BYPASS. Capture-IR loads 001, so the first bits shifted out are 1, 0, 0. The new instruction takes effect on the falling edge in Update-IR.
- R6: Under IDCODE, Capture-DR loads `ID_VALUE` into the 32-bit identification register, which is then shifted out LSB first.
- R7: Under BYPASS and under each reserved code (011, 101, 110), a single cell captures 0 and delays serial data by one clock.
- R8: Under 000, 010 and 100 the boundary register is selected. Capture-DR loads it with the following fields:
  - bits [N_IN-1:0] from `pin_in_i`;
  - the next N_OUT bits from `pad_do_o`;
  - the next bit from `pad_oe_o`;
  - the top N_FIX bits from the constant `FIX_VAL`.
- R9: With the boundary register selected, the falling edge in Update-DR copies its output-data and output-enable cells into the hold latch.
- R10: Under EXTEST, `pad_do_o` and `pad_oe_o` are driven from the hold latch.
- R11: Under SAMPLE-Z, `pad_oe_o` is 0 and `pad_do_o` follows `core_do_i`.
- R12: Under every other instruction the pads follow `core_do_i` and `core_oe_i`. Under every instruction `core_in_o` equals `pin_in_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous test reset |
| tms_i | input | 1 | Mode select, sampled on the rising edge |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, launched on the falling edge |
| tdo_oe_o | output | 1 | Serial output drive enable |
| pin_in_i | input | N_IN | Device input pin values |
| core_in_o | output | N_IN | Input values delivered to the core |
| core_do_i | input | N_OUT | Core output data |
| core_oe_i | input | 1 | Core output enable |
| pad_do_o | output | N_OUT | Data driven to the output pads |
| pad_oe_o | output | 1 | Output pad drive enable |

## Verification
A controller in the wrong state shows on `tdo_oe_o` at the very next falling edge, so the bench compares that pin against its own state model every cycle. A wrong instruction shows combinationally on the pad outputs as soon as the faulty update lands, and the bench catches it within one cycle. Corrupted shift or capture contents appear on `tdo_o` only after the register is shifted out, which takes up to 32 cycles. Each capture is therefore checked bit for bit against values computed from the pin, pad and constant fields.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;
  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tap_state_e;

  localparam int IR_W = 3;
  localparam int ID_W = 32;

  localparam logic [IR_W-1:0] INS_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] INS_IDCODE = 3'b001;
  localparam logic [IR_W-1:0] INS_SAMPZ  = 3'b010;
  localparam logic [IR_W-1:0] INS_SAMPLE = 3'b100;
  localparam logic [IR_W-1:0] INS_BYPASS = 3'b111;

  typedef enum logic [1:0] {DR_BSR, DR_ID, DR_BYP} dr_sel_e;
endpackage

// File: rtl/scan_port_fsm.sv
module scan_port_fsm
  import scan_port_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);
  tap_state_e state_q, state_d;

  always_comb begin
    unique case (state_q)
      TLR:    state_d = tms_i ? TLR    : RTI;
      RTI:    state_d = tms_i ? SEL_DR : RTI;
      SEL_DR: state_d = tms_i ? SEL_IR : CAP_DR;
      CAP_DR: state_d = tms_i ? EX1_DR : SH_DR;
      SH_DR:  state_d = tms_i ? EX1_DR : SH_DR;
      EX1_DR: state_d = tms_i ? UPD_DR : PAU_DR;
      PAU_DR: state_d = tms_i ? EX2_DR : PAU_DR;
      EX2_DR: state_d = tms_i ? UPD_DR : SH_DR;
      UPD_DR: state_d = tms_i ? SEL_DR : RTI;
      SEL_IR: state_d = tms_i ? TLR    : CAP_IR;
      CAP_IR: state_d = tms_i ? EX1_IR : SH_IR;
      SH_IR:  state_d = tms_i ? EX1_IR : SH_IR;
      EX1_IR: state_d = tms_i ? UPD_IR : PAU_IR;
      PAU_IR: state_d = tms_i ? EX2_IR : PAU_IR;
      EX2_IR: state_d = tms_i ? UPD_IR : SH_IR;
      UPD_IR: state_d = tms_i ? SEL_DR : RTI;
      default: state_d = TLR;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni) state_q <= TLR;
    else         state_q <= state_d;

  assign state_o = state_q;
endmodule

// File: rtl/scan_port_ir.sv
module scan_port_ir
  import scan_port_pkg::*;
(
  input  logic            tck_i,
  input  logic            rst_ni,
  input  tap_state_e      state_i,
  input  logic            tdi_i,
  output logic [IR_W-1:0] ir_o,
  output logic            lsb_o
);
  logic [IR_W-1:0] sh_q, ir_q;

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni)                sh_q <= '0;
    else if (state_i == CAP_IR) sh_q <= {{(IR_W-2){1'b0}}, 2'b01};
    else if (state_i == SH_IR)  sh_q <= {tdi_i, sh_q[IR_W-1:1]};

  // instruction changes only on the falling edge
  always_ff @(negedge tck_i or negedge rst_ni)
    if (!rst_ni)                ir_q <= INS_IDCODE;
    else if (state_i == TLR)    ir_q <= INS_IDCODE;
    else if (state_i == UPD_IR) ir_q <= sh_q;

  assign ir_o  = ir_q;
  assign lsb_o = sh_q[0];
endmodule

// File: rtl/scan_port_dr.sv
module scan_port_dr
  import scan_port_pkg::*;
#(
  parameter logic [ID_W-1:0] ID_VALUE = 32'h2B5C_30A7
) (
  input  logic       tck_i,
  input  logic       rst_ni,
  input  tap_state_e state_i,
  input  dr_sel_e    sel_i,
  input  logic       tdi_i,
  output logic       id_lsb_o,
  output logic       byp_o
);
  logic [ID_W-1:0] id_q;
  logic            byp_q;

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni) id_q <= '0;
    else if (sel_i == DR_ID) begin
      if (state_i == CAP_DR)     id_q <= ID_VALUE;
      else if (state_i == SH_DR) id_q <= {tdi_i, id_q[ID_W-1:1]};
    end

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni) byp_q <= 1'b0;
    else if (sel_i == DR_BYP) begin
      if (state_i == CAP_DR)     byp_q <= 1'b0;
      else if (state_i == SH_DR) byp_q <= tdi_i;
    end

  assign id_lsb_o = id_q[0];
  assign byp_o    = byp_q;
endmodule

// File: rtl/scan_port_bsr.sv
module scan_port_bsr
  import scan_port_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int N_FIX = 2,
  parameter logic [N_FIX-1:0] FIX_VAL = 2'b10
) (
  input  logic             tck_i,
  input  logic             rst_ni,
  input  tap_state_e       state_i,
  input  logic             sel_i,
  input  logic             tdi_i,
  input  logic [N_IN-1:0]  pin_i,
  input  logic [N_OUT-1:0] pad_do_i,
  input  logic             pad_oe_i,
  output logic             lsb_o,
  output logic [N_OUT-1:0] upd_do_o,
  output logic             upd_oe_o
);
  localparam int LEN    = N_IN + N_OUT + 1 + N_FIX;
  localparam int OUT_LO = N_IN;
  localparam int OE_POS = N_IN + N_OUT;

  logic [LEN-1:0] cap, sh_q;
  logic [N_OUT:0] upd_q;

  assign cap = {FIX_VAL, pad_oe_i, pad_do_i, pin_i};

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni) sh_q <= '0;
    else if (sel_i) begin
      if (state_i == CAP_DR)     sh_q <= cap;
      else if (state_i == SH_DR) sh_q <= {tdi_i, sh_q[LEN-1:1]};
    end

  // hold latch: pads never see shift ripple
  always_ff @(negedge tck_i or negedge rst_ni)
    if (!rst_ni)                         upd_q <= '0;
    else if (sel_i && state_i == UPD_DR) upd_q <= sh_q[OE_POS:OUT_LO];

  assign lsb_o    = sh_q[0];
  assign upd_do_o = upd_q[N_OUT-1:0];
  assign upd_oe_o = upd_q[N_OUT];
endmodule

// File: rtl/scan_port.sv
module scan_port
  import scan_port_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int N_FIX = 2,
  parameter logic [N_FIX-1:0] FIX_VAL = 2'b10,
  parameter logic [31:0] ID_VALUE = 32'h2B5C_30A7
) (
  input  logic             tck_i,
  input  logic             rst_ni,
  input  logic             tms_i,
  input  logic             tdi_i,
  output logic             tdo_o,
  output logic             tdo_oe_o,
  input  logic [N_IN-1:0]  pin_in_i,
  output logic [N_IN-1:0]  core_in_o,
  input  logic [N_OUT-1:0] core_do_i,
  input  logic             core_oe_i,
  output logic [N_OUT-1:0] pad_do_o,
  output logic             pad_oe_o
);
  tap_state_e       state_q;
  logic [IR_W-1:0]  ir_q;
  dr_sel_e          dr_sel;
  logic             ir_lsb, id_lsb, byp_bit, bsr_lsb, tdo_d;
  logic [N_OUT-1:0] upd_do;
  logic             upd_oe;

  scan_port_fsm u_fsm (
    .tck_i, .rst_ni, .tms_i, .state_o(state_q)
  );

  scan_port_ir u_ir (
    .tck_i, .rst_ni, .state_i(state_q), .tdi_i, .ir_o(ir_q), .lsb_o(ir_lsb)
  );

  always_comb begin
    unique case (ir_q)
      INS_EXTEST, INS_SAMPZ, INS_SAMPLE: dr_sel = DR_BSR;
      INS_IDCODE:                        dr_sel = DR_ID;
      default:                           dr_sel = DR_BYP;  // reserved codes alias here
    endcase
  end

  scan_port_dr #(.ID_VALUE(ID_VALUE)) u_dr (
    .tck_i, .rst_ni, .state_i(state_q), .sel_i(dr_sel), .tdi_i,
    .id_lsb_o(id_lsb), .byp_o(byp_bit)
  );

  scan_port_bsr #(
    .N_IN(N_IN), .N_OUT(N_OUT), .N_FIX(N_FIX), .FIX_VAL(FIX_VAL)
  ) u_bsr (
    .tck_i, .rst_ni, .state_i(state_q), .sel_i(dr_sel == DR_BSR), .tdi_i,
    .pin_i(pin_in_i), .pad_do_i(pad_do_o), .pad_oe_i(pad_oe_o),
    .lsb_o(bsr_lsb), .upd_do_o(upd_do), .upd_oe_o(upd_oe)
  );

  assign core_in_o = pin_in_i;

  always_comb begin
    pad_do_o = core_do_i;
    pad_oe_o = core_oe_i;
    if (ir_q == INS_EXTEST) begin
      pad_do_o = upd_do;
      pad_oe_o = upd_oe;
    end else if (ir_q == INS_SAMPZ) begin
      pad_oe_o = 1'b0;
    end
  end

  always_comb begin
    if (state_q == SH_IR) tdo_d = ir_lsb;
    else begin
      unique case (dr_sel)
        DR_BSR:  tdo_d = bsr_lsb;
        DR_ID:   tdo_d = id_lsb;
        default: tdo_d = byp_bit;
      endcase
    end
  end

  always_ff @(negedge tck_i or negedge rst_ni)
    if (!rst_ni) begin
      tdo_o    <= 1'b0;
      tdo_oe_o <= 1'b0;
    end else begin
      tdo_o    <= tdo_d;
      tdo_oe_o <= (state_q == SH_IR) || (state_q == SH_DR);
    end
endmodule

// File: rtl/scan_port_checker.sv
module scan_port_checker
  import scan_port_pkg::*;
(
  input logic            tck_i,
  input logic            rst_ni,
  input logic            tms_i,
  input logic            tdo_o,
  input logic            tdo_oe_o,
  input logic            pad_oe_o,
  input tap_state_e      state_q,
  input logic [IR_W-1:0] ir_q
);
  logic [2:0] hi_cnt;

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni)              hi_cnt <= '0;
    else if (!tms_i)          hi_cnt <= '0;
    else if (hi_cnt != 3'd7)  hi_cnt <= hi_cnt + 3'd1;

  a_r2_five_high_reset: assert property (@(posedge tck_i) disable iff (!rst_ni)
    hi_cnt >= 3'd5 |-> state_q == TLR);

  a_r2_tlr_idcode: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == TLR && $past(state_q) == TLR) |-> ir_q == INS_IDCODE);

  a_r4_tdo_shift_only: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_oe_o == (state_q == SH_DR || state_q == SH_IR));

  a_r5_capture_ir_lsb: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == SH_IR && $past(state_q) == CAP_IR) |-> tdo_o);

  a_r11_sampz_hiz: assert property (@(posedge tck_i) disable iff (!rst_ni)
    ir_q == INS_SAMPZ |-> !pad_oe_o);
endmodule

bind scan_port scan_port_checker u_chk (
  .tck_i(tck_i), .rst_ni(rst_ni), .tms_i(tms_i), .tdo_o(tdo_o),
  .tdo_oe_o(tdo_oe_o), .pad_oe_o(pad_oe_o), .state_q(state_q), .ir_q(ir_q)
);

// File: tb/scan_port_bench.sv
`timescale 1ns/1ps
module scan_port_bench;
  import scan_port_pkg::*;

  localparam int N_IN = 4, N_OUT = 4, N_FIX = 2;
  localparam int LEN = N_IN + N_OUT + 1 + N_FIX;
  localparam logic [N_FIX-1:0] FIXV = 2'b10;
  localparam logic [31:0] IDV = 32'h2B5C_30A7;

  logic tck_i = 1'b0, rst_ni = 1'b0, tms_i = 1'b1, tdi_i = 1'b0;
  logic tdo_o, tdo_oe_o, pad_oe_o, core_oe_i = 1'b0;
  logic [N_IN-1:0]  pin_in_i = '0, core_in_o;
  logic [N_OUT-1:0] core_do_i = '0, pad_do_o;

  int checks = 0, fails = 0;

  tap_state_e m_st = TLR;
  logic [2:0] m_ir = 3'b001, pend_ir = 3'b001;
  logic [N_OUT:0] m_lat = '0, pend_lat = '0;

  scan_port u_scan_port (.*);

  always #5 tck_i = ~tck_i;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic tap_state_e nxt(tap_state_e s, logic m);
    case (s)
      TLR:    return m ? TLR : RTI;
      RTI:    return m ? SEL_DR : RTI;
      SEL_DR: return m ? SEL_IR : CAP_DR;
      CAP_DR, SH_DR: return m ? EX1_DR : SH_DR;
      EX1_DR: return m ? UPD_DR : PAU_DR;
      PAU_DR: return m ? EX2_DR : PAU_DR;
      EX2_DR: return m ? UPD_DR : SH_DR;
      SEL_IR: return m ? TLR : CAP_IR;
      CAP_IR, SH_IR: return m ? EX1_IR : SH_IR;
      EX1_IR: return m ? UPD_IR : PAU_IR;
      PAU_IR: return m ? EX2_IR : PAU_IR;
      EX2_IR: return m ? UPD_IR : SH_IR;
      default: return m ? SEL_DR : RTI;  // both update states
    endcase
  endfunction

  function automatic bit bsr_ins(logic [2:0] c);
    return c == 3'b000 || c == 3'b010 || c == 3'b100;
  endfunction

  task automatic check_ports();
    logic [N_OUT-1:0] e_do;
    logic e_oe;
    e_do = core_do_i; e_oe = core_oe_i;
    if (m_ir == 3'b000) begin e_do = m_lat[N_OUT-1:0]; e_oe = m_lat[N_OUT]; end
    else if (m_ir == 3'b010) e_oe = 1'b0;
    chk("R4 tdo_oe", 64'(tdo_oe_o), 64'(m_st == SH_DR || m_st == SH_IR));
    chk("R10/R11/R12 pad_do", 64'(pad_do_o), 64'(e_do));
    chk("R10/R11/R12 pad_oe", 64'(pad_oe_o), 64'(e_oe));
    chk("R12 core_in", 64'(core_in_o), 64'(pin_in_i));
  endtask

  task automatic tick(input logic m, input logic d);
    tms_i = m; tdi_i = d;
    @(posedge tck_i);
    m_st = nxt(m_st, m);
    @(negedge tck_i); #1;
    if (m_st == TLR) m_ir = 3'b001;
    if (m_st == UPD_IR) m_ir = pend_ir;
    if (m_st == UPD_DR && bsr_ins(m_ir)) m_lat = pend_lat;  // R9
    check_ports();
  endtask

  task automatic shift_ir(input logic [2:0] code);
    logic [2:0] got;
    tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    pend_ir = code;
    for (int i = 0; i < 3; i++) begin
      got[i] = tdo_o;
      tick(i == 2, code[i]);
    end
    chk("R5 capture-IR", 64'(got), 64'h1);
    tick(1'b1, 1'b0); tick(1'b0, 1'b0);
  endtask

  task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo_o;
      tick(i == n - 1, din[i]);
    end
    pend_lat = din[N_IN +: N_OUT+1];
    tick(1'b1, 1'b0); tick(1'b0, 1'b0);
  endtask

  function automatic logic [63:0] exp_shift(int len, logic [63:0] cap, logic [63:0] din, int n);
    logic [63:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = (i < len) ? cap[i] : din[i - len];
    return r;
  endfunction

  initial begin
    #(10 * 150000);
    fails++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] got, din, cap, g2;
    repeat (3) @(negedge tck_i);
    #1;
    chk("R1 tdo_oe in reset", 64'(tdo_oe_o), 64'h0);
    chk("R1 pad_oe in reset", 64'(pad_oe_o), 64'(core_oe_i));
    rst_ni = 1'b1;
    tick(1'b0, 1'b0);

    // R1 R6: IDCODE is the instruction after reset
    shift_dr(32, 64'h0, got);
    chk("R6 idcode", got, 64'(IDV));

    // R3: shift through pause loop
    tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    got = '0;
    for (int i = 0; i < 16; i++) begin got[i] = tdo_o; tick(i == 15, 1'b0); end
    tick(1'b0, 1'b0); tick(1'b0, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0);
    for (int i = 16; i < 32; i++) begin got[i] = tdo_o; tick(i == 31, 1'b0); end
    tick(1'b1, 1'b0); tick(1'b0, 1'b0);
    chk("R3 pause resume", got, 64'(IDV));

    // R7: bypass and reserved codes
    din = 64'hA5;
    shift_ir(3'b111);
    shift_dr(8, din, got);
    chk("R7 bypass 111", got, exp_shift(1, 64'h0, din, 8));
    foreach (din[k]) if (k < 3) begin
      logic [2:0] rc;
      rc = (k == 0) ? 3'b011 : (k == 1) ? 3'b101 : 3'b110;
      shift_ir(rc);
      shift_dr(8, 64'h3C, g2);
      chk("R7 reserved", g2, exp_shift(1, 64'h0, 64'h3C, 8));
    end

    // R8 R9: SAMPLE/PRELOAD captures pins/pads, preloads latch
    pin_in_i = 4'h9; core_do_i = 4'h6; core_oe_i = 1'b1;
    shift_ir(3'b100);
    din = 64'({2'b00, 1'b1, 4'hC, 4'h3});
    shift_dr(LEN, din, got);
    cap = 64'({FIXV, 1'b1, 4'h6, 4'h9});
    chk("R8 sample capture", got, cap);

    // R10: EXTEST drives latch; capture sees driven pads
    shift_ir(3'b000);
    chk("R10 extest do", 64'(pad_do_o), 64'hC);
    pin_in_i = 4'h5; core_do_i = 4'h1;
    din = 64'({2'b00, 1'b0, 4'hA, 4'h0});
    shift_dr(LEN, din, got);
    chk("R8 extest capture", got, 64'({FIXV, 1'b1, 4'hC, 4'h5}));
    chk("R9 latch update oe", 64'(pad_oe_o), 64'h0);
    chk("R9 latch update do", 64'(pad_do_o), 64'hA);

    // R11: SAMPLE-Z
    shift_ir(3'b010);
    chk("R11 sampz oe", 64'(pad_oe_o), 64'h0);
    shift_dr(LEN, 64'h0, got);
    chk("R11 sampz capture", got, 64'({FIXV, 1'b0, 4'h1, 4'h5}));

    // R2: five TMS-high edges from Shift-DR
    shift_ir(3'b111);
    tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
    chk("R2 tlr oe", 64'(tdo_oe_o), 64'h0);
    tick(1'b0, 1'b0);
    shift_dr(32, 64'h0, got);
    chk("R2 idcode after tlr", got, 64'(IDV));

    // R1: async reset mid-run
    shift_ir(3'b000);
    tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
    #2 rst_ni = 1'b0;
    #1;
    m_st = TLR; m_ir = 3'b001; m_lat = '0;
    chk("R1 async tdo_oe", 64'(tdo_oe_o), 64'h0);
    chk("R1 async pads", 64'(pad_oe_o), 64'(core_oe_i));
    @(negedge tck_i); #1;
    rst_ni = 1'b1;
    tick(1'b0, 1'b0);
    shift_dr(32, 64'h0, got);
    chk("R1 idcode after reset", got, 64'(IDV));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule